// File: doc/BRIEF.md
# Three-Level Page Table Walker

This block turns a 64-bit virtual address into a physical address for one access at a time. A request carries the address, a privilege mode and an access kind. Two kinds of request finish without any table lookup. Requests in physical mode pass the address straight through. Addresses inside the kernel superpage window are relocated directly. An address that is not properly sign-extended is rejected at once. Every other address starts a walk of up to three table levels. The walk begins at a table base supplied with the request. Each step is a single 64-bit read from page-table memory over a request/response pair.

The walk finishes with a one-cycle `done` pulse. At that point the block reports a success flag, a fault code, the physical address and a three-bit permission mask. These results hold until the next walk completes. Raising the trap and caching translations are left to the surrounding logic.

Top module: `pgwalk`

## Requirements
- R1: A mode value of 4 or above (physical) completes with `resOk`=1, `physAddr` equal to the virtual address, `perm`=3'b111, no memory read, and `done` in the second cycle after the request is accepted.
- R2: In a non-physical mode, if bits 63:43 of the address are not all copies of bit 63, the result is an access violation (code 0) with no memory read.
- R3: A canonical address with bit 63 set and bits 42:41 equal to 2'b10 is a superpage. In kernel mode (0) it succeeds with perm 3'b111 and a physical address made of virtual bits 39:0, plus virtual bit 40 moved to physical bit 43, with all other bits zero. Any other non-physical mode gets an access violation. Either way no memory read is made.
- R4: Otherwise the walker reads three entries in turn, one `memReqValid` pulse each. The entry addresses are base + VA[42:33]*8, then base + VA[32:23]*8, then base + VA[22:13]*8. The first base is `ptBase`; each later base is bits 63:32 of the previous entry shifted left by 13.
- R5: An entry at any level with bit 0 (valid) clear ends the walk with code 4 (translation not valid).
- R6: A level-1 or level-2 entry that is valid but has bit 8 (kernel read enable) clear ends the walk with code 0.
- R7: In the leaf entry, for mode m (0..3), bit 8+m grants read and execute and bit 12+m grants write. Access kind 0 is read, 1 is write, 2 is execute and 3 is a probe that requires nothing. A required permission that is not granted gives code 0.
- R8: Leaf bits 1, 2 and 3 remove read, write and execute permission respectively. If the required permission is then missing, the result is code 1 for read, 2 for write or 3 for execute. A probe never faults at this stage.
- R9: On success `resOk`=1, `faultCode`=0, `perm` is the masked permission (bit 0 read, bit 1 write, bit 2 execute), and `physAddr` is leaf bits 63:32 shifted left by 13, ORed with VA[12:0]. On any fault `resOk`=0, `physAddr`=0 and `perm`=0.
- R10: `done` is high for exactly one cycle per accepted request. Results change only in that cycle. `reqValid` is ignored while a walk is in progress.
- R11: After reset, `done`, `memReqValid`, `resOk`, `faultCode`, `physAddr` and `perm` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| reqValid | input | 1 | Start a translation (taken only when idle) |
| reqVaddr | input | 64 | Virtual address |
| reqMode | input | 3 | 0 kernel, 1 executive, 2 supervisor, 3 user, 4+ physical |
| reqAccess | input | 2 | 0 read, 1 write, 2 execute, 3 probe |
| ptBase | input | 64 | Level-1 table base address |
| memReqValid | output | 1 | One-cycle table read request |
| memReqAddr | output | 64 | Table entry address |
| memRspValid | input | 1 | Read data valid |
| memRspData | input | 64 | Table entry read back |
| done | output | 1 | Result valid pulse |
| resOk | output | 1 | Translation succeeded |
| faultCode | output | 3 | 0 access violation, 1/2/3 fault on read/write/execute, 4 not valid |
| physAddr | output | 64 | Translated address |
| perm | output | 3 | Granted permissions {execute, write, read} |

## Verification
The bench builds the block with its default parameters: 13 page-offset bits, a 43-bit implemented virtual range, three levels of 10-bit indices and 64-bit entries. With these values the three index fields together with the offset cover every implemented address bit. Bit 40 therefore lands at bit 43 in superpage results, and random sign-extended addresses regularly fall into the superpage window as well as the ordinary walk range. Page frames are kept to 20 random bits, so every table touched by a walk fits in a sparse bench-side memory. This lets random flag patterns at each level reach every fault code, including early stops at levels 1 and 2.

// File: rtl/pgwalk_pkg.sv
package pgwalk_pkg;

  // fault codes reported with done
  typedef enum logic [2:0] {
    FLT_ACV = 3'd0,
    FLT_FOR = 3'd1,
    FLT_FOW = 3'd2,
    FLT_FOE = 3'd3,
    FLT_TNV = 3'd4
  } faultT;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DECIDE,
    ST_ISSUE,
    ST_WAIT,
    ST_FIN
  } walkStateT;

  // control -> datapath strobes
  typedef struct packed {
    logic capture;
    logic fastLoad;
    logic stepLoad;
    logic pteLoad;
  } strobeT;

  // datapath -> control status
  typedef struct packed {
    logic fastPath;
    logic pteStop;
  } statusT;

  // entry bit positions
  localparam int PTE_VALID = 0;
  localparam int PTE_FO_LO = 1;
  localparam int PTE_KRE   = 8;
  localparam int PTE_KWE   = 12;

endpackage

// File: rtl/pgwalk_dp.sv
module pgwalk_dp
  import pgwalk_pkg::*;
#(
  parameter int VA_W      = 64,
  parameter int PAGE_BITS = 13,
  parameter int IMPL_VA   = 43,
  parameter int IDX_W     = 10,
  parameter int LEVELS    = 3,
  parameter int LVL_W     = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  strobeT           strb,
  input  logic [LVL_W-1:0] lvl,
  input  logic [VA_W-1:0]  reqVaddr,
  input  logic [2:0]       reqMode,
  input  logic [1:0]       reqAccess,
  input  logic [VA_W-1:0]  ptBase,
  input  logic [VA_W-1:0]  memRspData,
  output statusT           stat,
  output logic [VA_W-1:0]  memReqAddr,
  output logic             resOk,
  output logic [2:0]       resCode,
  output logic [VA_W-1:0]  resPhys,
  output logic [2:0]       resPerm
);

  localparam int FRAME_W     = VA_W / 2;
  localparam int ENTRY_SHIFT = $clog2(VA_W / 8);
  localparam int BIT_IDX_W   = $clog2(VA_W);
  localparam int SP_MOVE     = IMPL_VA - 3;
  localparam int SP_DEST     = IMPL_VA;

  logic [VA_W-1:0] vaReg;
  logic [2:0]      modeReg;
  logic [1:0]      accReg;
  logic [VA_W-1:0] baseReg;

  // index fields, level 0 is the top table
  logic [IDX_W-1:0] idxArr [LEVELS];
  logic [IDX_W-1:0] curIdx;

  for (genvar g = 0; g < LEVELS; g++) begin : gIdx
    assign idxArr[g] = vaReg[PAGE_BITS + IDX_W*(LEVELS-1-g) +: IDX_W];
  end

  always_comb begin
    curIdx = '0;
    for (int k = 0; k < LEVELS; k++) begin
      if (lvl == LVL_W'(k)) curIdx = idxArr[k];
    end
  end

  assign memReqAddr = baseReg + (VA_W'(curIdx) << ENTRY_SHIFT);

  // fast path classification
  logic            isPhys, isCanon, isSuper;
  logic            fastOk;
  logic [2:0]      fastCode;
  logic [VA_W-1:0] fastPhys;
  logic [2:0]      fastPerm;

  assign isPhys  = modeReg[2];
  assign isCanon = (vaReg[VA_W-1:IMPL_VA] == {(VA_W-IMPL_VA){vaReg[VA_W-1]}});
  assign isSuper = vaReg[VA_W-1] && (vaReg[IMPL_VA-1 -: 2] == 2'b10);

  always_comb begin
    fastOk   = 1'b0;
    fastCode = FLT_ACV;
    fastPhys = '0;
    fastPerm = '0;
    if (isPhys) begin
      fastOk   = 1'b1;
      fastPhys = vaReg;
      fastPerm = 3'b111;
    end else if (isCanon && isSuper && modeReg[1:0] == 2'd0) begin
      fastOk   = 1'b1;
      fastPhys = VA_W'(vaReg[SP_MOVE-1:0]) | (VA_W'(vaReg[SP_MOVE]) << SP_DEST);
      fastPerm = 3'b111;
    end
  end

  assign stat.fastPath = isPhys || !isCanon || isSuper;

  // entry evaluation
  logic [VA_W-1:0]      pte;
  logic                 isLeaf, pteValid, pteKre, rdEn, wrEn;
  logic [BIT_IDX_W-1:0] rdIdx, wrIdx;
  logic [2:0]           need, prot, masked;
  logic [VA_W-1:0]      frame;
  logic                 pOk;
  logic [2:0]           pCode;
  logic [VA_W-1:0]      pPhys;
  logic [2:0]           pPerm;
  logic                 unusedPteBits;

  assign pte      = memRspData;
  assign isLeaf   = (lvl == LVL_W'(LEVELS-1));
  assign pteValid = pte[PTE_VALID];
  assign pteKre   = pte[PTE_KRE];
  assign rdIdx    = BIT_IDX_W'(PTE_KRE) + BIT_IDX_W'(modeReg[1:0]);
  assign wrIdx    = BIT_IDX_W'(PTE_KWE) + BIT_IDX_W'(modeReg[1:0]);
  assign rdEn     = pte[rdIdx];
  assign wrEn     = pte[wrIdx];
  assign frame    = VA_W'(pte[VA_W-1 -: FRAME_W]) << PAGE_BITS;
  assign prot     = {rdEn, wrEn, rdEn};
  assign masked   = prot & ~pte[PTE_FO_LO +: 3];
  assign unusedPteBits = ^{pte[7:4], pte[VA_W-FRAME_W-1:16]};

  always_comb begin
    case (accReg)
      2'd0:    need = 3'b001;
      2'd1:    need = 3'b010;
      2'd2:    need = 3'b100;
      default: need = 3'b000;
    endcase
  end

  assign stat.pteStop = !pteValid || (!isLeaf && !pteKre);

  always_comb begin
    pOk   = 1'b0;
    pCode = FLT_ACV;
    pPhys = '0;
    pPerm = '0;
    if (!pteValid) begin
      pCode = FLT_TNV;
    end else if (!isLeaf) begin
      pCode = FLT_ACV;
    end else if (need != 3'b000 && (prot & need) == 3'b000) begin
      pCode = FLT_ACV;
    end else if (need != 3'b000 && (masked & need) == 3'b000) begin
      pCode = need[2] ? FLT_FOE : (need[1] ? FLT_FOW : FLT_FOR);
    end else begin
      pOk   = 1'b1;
      pPhys = frame | VA_W'(vaReg[PAGE_BITS-1:0]);
      pPerm = masked;
    end
  end

  // registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      vaReg   <= '0;
      modeReg <= '0;
      accReg  <= '0;
      baseReg <= '0;
      resOk   <= 1'b0;
      resCode <= '0;
      resPhys <= '0;
      resPerm <= '0;
    end else begin
      if (strb.capture) begin
        vaReg   <= reqVaddr;
        modeReg <= reqMode;
        accReg  <= reqAccess;
        baseReg <= ptBase;
      end
      if (strb.stepLoad) baseReg <= frame;
      if (strb.fastLoad) begin
        resOk   <= fastOk;
        resCode <= fastCode;
        resPhys <= fastPhys;
        resPerm <= fastPerm;
      end
      if (strb.pteLoad) begin
        resOk   <= pOk;
        resCode <= pCode;
        resPhys <= pPhys;
        resPerm <= pPerm;
      end
    end
  end

endmodule

// File: rtl/pgwalk_ctrl.sv
module pgwalk_ctrl
  import pgwalk_pkg::*;
#(
  parameter int LEVELS = 3,
  parameter int LVL_W  = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  logic             memRspValid,
  input  statusT           stat,
  output strobeT           strb,
  output logic [LVL_W-1:0] lvl,
  output logic             memReqValid,
  output logic             done
);

  walkStateT state;
  logic      lastLvl;

  assign lastLvl = (lvl == LVL_W'(LEVELS-1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      lvl   <= '0;
    end else begin
      case (state)
        ST_IDLE: if (reqValid) begin
          state <= ST_DECIDE;
          lvl   <= '0;
        end
        ST_DECIDE: state <= stat.fastPath ? ST_FIN : ST_ISSUE;
        ST_ISSUE:  state <= ST_WAIT;
        ST_WAIT: if (memRspValid) begin
          if (stat.pteStop || lastLvl) begin
            state <= ST_FIN;
          end else begin
            lvl   <= lvl + 1'b1;
            state <= ST_ISSUE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    strb.capture  = (state == ST_IDLE) && reqValid;
    strb.fastLoad = (state == ST_DECIDE) && stat.fastPath;
    strb.stepLoad = (state == ST_WAIT) && memRspValid && !stat.pteStop && !lastLvl;
    strb.pteLoad  = (state == ST_WAIT) && memRspValid && (stat.pteStop || lastLvl);
  end

  assign memReqValid = (state == ST_ISSUE);
  assign done        = (state == ST_FIN);

endmodule

// File: rtl/pgwalk.sv
module pgwalk
  import pgwalk_pkg::*;
#(
  parameter int VA_W      = 64,
  parameter int PAGE_BITS = 13,
  parameter int IMPL_VA   = 43,
  parameter int IDX_W     = 10,
  parameter int LEVELS    = 3
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            reqValid,
  input  logic [VA_W-1:0] reqVaddr,
  input  logic [2:0]      reqMode,
  input  logic [1:0]      reqAccess,
  input  logic [VA_W-1:0] ptBase,
  output logic            memReqValid,
  output logic [VA_W-1:0] memReqAddr,
  input  logic            memRspValid,
  input  logic [VA_W-1:0] memRspData,
  output logic            done,
  output logic            resOk,
  output logic [2:0]      faultCode,
  output logic [VA_W-1:0] physAddr,
  output logic [2:0]      perm
);

  localparam int LVL_W = $clog2(LEVELS + 1);

  strobeT           strb;
  statusT           stat;
  logic [LVL_W-1:0] lvl;

  pgwalk_ctrl #(.LEVELS(LEVELS), .LVL_W(LVL_W)) uCtrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .memRspValid(memRspValid),
    .stat(stat), .strb(strb), .lvl(lvl), .memReqValid(memReqValid), .done(done)
  );

  pgwalk_dp #(
    .VA_W(VA_W), .PAGE_BITS(PAGE_BITS), .IMPL_VA(IMPL_VA),
    .IDX_W(IDX_W), .LEVELS(LEVELS), .LVL_W(LVL_W)
  ) uDp (
    .clk(clk), .rstN(rstN), .strb(strb), .lvl(lvl),
    .reqVaddr(reqVaddr), .reqMode(reqMode), .reqAccess(reqAccess),
    .ptBase(ptBase), .memRspData(memRspData), .stat(stat),
    .memReqAddr(memReqAddr), .resOk(resOk), .resCode(faultCode),
    .resPhys(physAddr), .resPerm(perm)
  );

endmodule

// File: rtl/pgwalk_chk.sv
module pgwalk_chk #(
  parameter int VA_W = 64
) (
  input logic            clk,
  input logic            rstN,
  input logic            memReqValid,
  input logic            done,
  input logic            resOk,
  input logic [2:0]      faultCode,
  input logic [VA_W-1:0] physAddr,
  input logic [2:0]      perm
);

  p_req_pulse_r4: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid |=> !memReqValid);

  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  p_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    !done |-> ($stable(physAddr) && $stable(perm) && $stable(resOk) && $stable(faultCode)));

  p_code_range_r5: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (faultCode <= 3'd4));

  p_fault_blank_r9: assert property (@(posedge clk) disable iff (!rstN)
    (done && !resOk) |-> (physAddr == '0 && perm == 3'b000));

  p_ok_code_r9: assert property (@(posedge clk) disable iff (!rstN)
    (done && resOk) |-> (faultCode == 3'd0));

endmodule

bind pgwalk pgwalk_chk #(.VA_W(VA_W)) uChk (
  .clk(clk), .rstN(rstN), .memReqValid(memReqValid), .done(done),
  .resOk(resOk), .faultCode(faultCode), .physAddr(physAddr), .perm(perm)
);

// File: tb/pgwalk_test.sv
`timescale 1ns/1ps
module pgwalk_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic [63:0] reqVaddr = '0;
  logic [2:0]  reqMode = '0;
  logic [1:0]  reqAccess = '0;
  logic [63:0] ptBase = '0;
  logic        memReqValid;
  logic [63:0] memReqAddr;
  logic        memRspValid = 1'b0;
  logic [63:0] memRspData = '0;
  logic        done, resOk;
  logic [2:0]  faultCode, perm;
  logic [63:0] physAddr;

  always #2.5 clk = ~clk;

  pgwalk uut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqVaddr(reqVaddr),
    .reqMode(reqMode), .reqAccess(reqAccess), .ptBase(ptBase),
    .memReqValid(memReqValid), .memReqAddr(memReqAddr),
    .memRspValid(memRspValid), .memRspData(memRspData), .done(done),
    .resOk(resOk), .faultCode(faultCode), .physAddr(physAddr), .perm(perm)
  );

  int nChecks = 0;
  int nFails  = 0;
  logic [63:0] memModel [logic [63:0]];

  task automatic check(input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic logic [63:0] rdMem(input logic [63:0] a);
    return memModel.exists(a) ? memModel[a] : 64'd0;
  endfunction

  function automatic logic [63:0] entryAddr(input logic [63:0] base,
                                            input logic [63:0] va, input int lv);
    return base + (((va >> (13 + 10 * (2 - lv))) & 64'h3ff) << 3);
  endfunction

  // expected outcome from the requirements
  function automatic void predict(input logic [63:0] va, input logic [2:0] mode,
      input logic [1:0] acc, input logic [63:0] base,
      output logic eOk, output logic [2:0] eCode, output logic [63:0] ePhys,
      output logic [2:0] ePerm, output int eReads,
      output logic [2:0][63:0] eAddr, output string tag);
    logic [63:0] tb, pte;
    logic [2:0]  need, prot, masked;
    int m;
    eOk = 0; eCode = 0; ePhys = 0; ePerm = 0; eReads = 0; eAddr = '0; tag = "R2";
    pte = 0;
    need = (acc == 2'd0) ? 3'b001 : (acc == 2'd1) ? 3'b010 : (acc == 2'd2) ? 3'b100 : 3'b000;
    if (mode[2]) begin
      eOk = 1; ePhys = va; ePerm = 3'b111; tag = "R1"; return;
    end
    if (va[63:43] != {21{va[63]}}) begin
      tag = "R2"; return;
    end
    if (va[63] && va[42:41] == 2'b10) begin
      tag = "R3";
      if (mode == 3'd0) begin
        eOk = 1; ePerm = 3'b111;
        ePhys = {20'b0, va[40], 3'b0, va[39:0]};
      end
      return;
    end
    tb = base;
    for (int l = 0; l < 3; l++) begin
      eAddr[l] = entryAddr(tb, va, l);
      eReads++;
      pte = rdMem(eAddr[l]);
      if (!pte[0]) begin eCode = 3'd4; tag = "R5"; return; end
      if (l < 2) begin
        if (!pte[8]) begin eCode = 3'd0; tag = "R6"; return; end
        tb = {32'b0, pte[63:32]} << 13;
      end
    end
    m = int'(mode[1:0]);
    prot = {pte[8 + m], pte[12 + m], pte[8 + m]};
    if (need != 0 && (prot & need) == 0) begin eCode = 3'd0; tag = "R7"; return; end
    masked = prot & ~pte[3:1];
    if (need != 0 && (masked & need) == 0) begin
      eCode = need[2] ? 3'd3 : need[1] ? 3'd2 : 3'd1; tag = "R8"; return;
    end
    eOk = 1; ePerm = masked; tag = "R9";
    ePhys = ({32'b0, pte[63:32]} << 13) | {51'b0, va[12:0]};
  endfunction

  task automatic buildTables(input logic [63:0] va, input logic [63:0] base,
      input logic [15:0] f1, input logic [15:0] f2, input logic [15:0] f3,
      input logic [31:0] p1, input logic [31:0] p2, input logic [31:0] p3);
    memModel.delete();
    memModel[entryAddr(base, va, 0)] = {p1, 16'h0, f1};
    memModel[entryAddr({32'b0, p1} << 13, va, 1)] = {p2, 16'h0, f2};
    memModel[entryAddr({32'b0, p2} << 13, va, 2)] = {p3, 16'h0, f3};
  endtask

  task automatic doWalk(input logic [63:0] va, input logic [2:0] mode,
                        input logic [1:0] acc, input logic [63:0] base, input bit poke);
    logic eOk; logic [2:0] eCode, ePerm; logic [63:0] ePhys;
    int eReads; logic [2:0][63:0] eAddr; string tag;
    logic [2:0][63:0] gotAddr;
    logic [63:0] rsp;
    int cyc = 0;
    int reads = 0;
    bit poked = 0;
    gotAddr = '0;
    predict(va, mode, acc, base, eOk, eCode, ePhys, ePerm, eReads, eAddr, tag);
    @(negedge clk);
    reqValid = 1'b1; reqVaddr = va; reqMode = mode; reqAccess = acc; ptBase = base;
    @(negedge clk);
    reqValid = 1'b0;
    while (!done && cyc < 1000) begin
      if (memReqValid) begin
        if (reads < 3) gotAddr[reads] = memReqAddr;
        reads++;
        rsp = rdMem(memReqAddr);
        if (poke && !poked) begin
          reqValid = 1'b1; reqVaddr = ~va; reqMode = 3'd4; ptBase = ~base; poked = 1;
        end
        @(negedge clk);
        reqValid = 1'b0;
        repeat ($urandom_range(0, 3)) begin @(negedge clk); cyc++; end
        memRspValid = 1'b1; memRspData = rsp;
        @(negedge clk);
        memRspValid = 1'b0; memRspData = {$urandom, $urandom};
        cyc += 2;
      end else begin
        @(negedge clk);
        cyc++;
      end
    end
    if (!done) begin
      nChecks++; nFails++;
      $display("FAIL R10 walk hung: actual no done expected done");
      return;
    end
    check(tag, "ok", {63'b0, resOk}, {63'b0, eOk});
    check(tag, "code", {61'b0, faultCode}, {61'b0, eCode});
    check(tag, "phys", physAddr, ePhys);
    check(tag, "perm", {61'b0, perm}, {61'b0, ePerm});
    check("R4", "reads", 64'(reads), 64'(eReads));
    check("R4", "addrs", 64'(gotAddr[0] ^ gotAddr[1] * 3 ^ gotAddr[2] * 7),
                         64'(eAddr[0] ^ eAddr[1] * 3 ^ eAddr[2] * 7));
    if (eReads == 0) check("R1", "fast latency", 64'(cyc), 64'd1);
    @(negedge clk);
    check("R10", "done pulse", {63'b0, done}, 64'd0);
    check("R10", "result hold", physAddr, ePhys);
    if (poke) begin
      for (int k = 0; k < 4; k++) begin
        check("R10", "ignored request", {62'b0, done, memReqValid}, 64'd0);
        @(negedge clk);
      end
    end
  endtask

  initial begin
    #1000000;
    nFails++;
    $display("FAIL R10 watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    logic [63:0] va, base;
    logic [15:0] f1, f2, f3;
    int kind;
    logic [2:0] mode;
    void'($urandom(32'h1F2E3D4C));
    repeat (3) @(negedge clk);
    // R11 reset state
    check("R11", "reset outputs", {59'b0, done, memReqValid, resOk, faultCode == 0, perm == 0},
          64'd3);
    check("R11", "reset phys", physAddr, 64'd0);
    rstN = 1'b1;

    base = 64'h0020_0000;
    va   = 64'h0000_0123_4567_89AB;
    // R1 physical mode
    doWalk(64'hDEAD_BEEF_0000_1234, 3'd4, 2'd1, base, 0);
    doWalk(64'h0000_0800_0000_0001, 3'd7, 2'd2, base, 0);
    // R2 non-canonical
    doWalk(64'h0000_0800_0000_0000, 3'd0, 2'd0, base, 0);
    // R3 superpage
    doWalk(64'hFFFF_FD12_3456_789A, 3'd0, 2'd0, base, 0);
    doWalk(64'hFFFF_FD12_3456_789A, 3'd3, 2'd0, base, 0);
    // R9 full walk, R4 addressing
    buildTables(va, base, 16'hFF01, 16'hFF01, 16'hFF01, 32'h111, 32'h222, 32'h333);
    doWalk(va, 3'd0, 2'd0, base, 0);
    // R5 invalid at level 1 and level 3
    buildTables(va, base, 16'hFF00, 16'hFF01, 16'hFF01, 32'h111, 32'h222, 32'h333);
    doWalk(va, 3'd0, 2'd0, base, 0);
    buildTables(va, base, 16'hFF01, 16'hFF01, 16'hFF00, 32'h111, 32'h222, 32'h333);
    doWalk(va, 3'd0, 2'd0, base, 0);
    // R6 level-2 kernel read clear
    buildTables(va, base, 16'hFF01, 16'hFE01, 16'hFF01, 32'h111, 32'h222, 32'h333);
    doWalk(va, 3'd1, 2'd0, base, 0);
    // R7 user write not granted, user read granted
    buildTables(va, base, 16'hFF01, 16'hFF01, 16'h7F01, 32'h111, 32'h222, 32'h333);
    doWalk(va, 3'd3, 2'd1, base, 0);
    doWalk(va, 3'd3, 2'd0, base, 0);
    // R8 fault-on outcomes and probe
    buildTables(va, base, 16'hFF01, 16'hFF01, 16'hFF09, 32'h111, 32'h222, 32'h333);
    doWalk(va, 3'd0, 2'd2, base, 0);
    buildTables(va, base, 16'hFF01, 16'hFF01, 16'hFF05, 32'h111, 32'h222, 32'h333);
    doWalk(va, 3'd0, 2'd1, base, 0);
    buildTables(va, base, 16'hFF01, 16'hFF01, 16'hFF03, 32'h111, 32'h222, 32'h333);
    doWalk(va, 3'd0, 2'd0, base, 0);
    buildTables(va, base, 16'hFF01, 16'hFF01, 16'hFF0F, 32'h111, 32'h222, 32'h333);
    doWalk(va, 3'd2, 2'd3, base, 0);
    // R10 request during a walk is ignored
    buildTables(va, base, 16'hFF01, 16'hFF01, 16'hFF01, 32'h444, 32'h555, 32'h666);
    doWalk(va, 3'd0, 2'd1, base, 1);

    // constrained random mix
    for (int it = 0; it < 400; it++) begin
      kind = $urandom_range(0, 9);
      va = {$urandom, $urandom};
      if (kind == 0) begin
        va[63] = 1'b0; va[50] = 1'b1;
      end else if (kind == 1) begin
        va[63:42] = '1; va[41] = 1'b0;
      end else begin
        va[63:43] = {21{va[42]}};
      end
      mode = (kind == 2) ? 3'(4 + $urandom_range(0, 3)) : 3'($urandom_range(0, 3));
      base = 64'($urandom_range(1, 255)) << 13;
      f1 = 16'($urandom) & 16'hFF0F; f1[0] = ($urandom_range(0, 9) != 0); f1[8] = ($urandom_range(0, 9) != 0);
      f2 = 16'($urandom) & 16'hFF0F; f2[0] = ($urandom_range(0, 9) != 0); f2[8] = ($urandom_range(0, 9) != 0);
      f3 = 16'($urandom) & 16'hFF0F; f3[0] = ($urandom_range(0, 9) != 0);
      buildTables(va, base, f1, f2, f3,
                  32'($urandom_range(1, 20'hFFFFF)), 32'($urandom_range(1, 20'hFFFFF)),
                  32'($urandom_range(1, 20'hFFFFF)));
      doWalk(va, mode, 2'($urandom_range(0, 3)), base, (it % 50) == 7);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

endmodule